// File: doc/BRIEF.md
# Neighbour Reset Boot-Mode Controller

This block decides when a mesh node goes into boot mode and from which neighbour port it loads itself. Each of the neighbour ports carries a reset line into the node. When an unmasked line is raised, the controller locks onto that port and enters boot mode. While in boot mode it enables reads on that port and passes every valid word it receives to the node's memory-space write path. The node stays in boot mode until the memory-space decoder reports the boot-exit write. The node then runs. A later neighbour reset can pull it back into boot mode.

A programmable mask lets software ignore chosen neighbours, such as ports on the mesh edge or a faulty node. The controller also drives the valid-bit clear used by the buffer and processor-interface registers. That clear comes only from the power-up reset, never from a neighbour reset, so a node that is reprogrammed while live keeps its buffered data.

Top module: `bootctl_top`

## Requirements
- R1: From power-up reset (`rst_n` low) until the first accepted neighbour reset, `boot_mode_o` and `run_mode_o` are 0, `port_rd_en_o` is all zero and `mem_wr_en_o` is 0.
- R2: When no port holds the lock and an unmasked bit of `nbr_rst_i` is 1 at a clock edge, then after that edge `boot_mode_o` is 1, `boot_port_o` holds that port's index, and `port_rd_en_o` has only bit `boot_port_o` set.
- R3: In boot mode, `mem_wr_en_o` equals `port_valid_i[boot_port_o]` and `mem_wr_data_o` equals that port's word `port_word_i[p*W +: W]`. Words and valid bits on other ports have no effect. Outside boot mode, `mem_wr_en_o` and `port_rd_en_o` are 0.
- R4: When several unmasked reset lines are 1 in the same accepting cycle, the lowest-numbered port wins.
- R5: After a port is accepted, it keeps the lock while its own reset line stays 1, and other lines are ignored. At the first edge where the owner's line is seen at 0, another unmasked raised line is accepted at once.
- R6: `clr_valid_o` is 1 during power-up reset and in the first cycle after reset is released, and 0 after that. Accepting a neighbour reset never raises it.
- R7: A `boot_exit_i` pulse in boot mode moves the node to run mode (`run_mode_o`=1, `boot_mode_o`=0) after the edge. In idle or run mode it has no effect. If a reset is accepted in the same cycle, the node stays in boot mode on the new port.
- R8: From run mode, an accepted neighbour reset returns the node to boot mode on the new port.
- R9: `mask_we_i` loads `mask_i` into the mask at the edge. Mask bit p = 1 makes port p's reset line ignored. Power-up reset clears the mask to zero, so every port is honoured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-up reset, active low |
| nbr_rst_i | input | NPORTS | Reset lines from the neighbours, bit p for port p |
| mask_we_i | input | 1 | Load enable for the reset mask |
| mask_i | input | NPORTS | New mask value, 1 ignores the port |
| boot_exit_i | input | 1 | Boot-exit write seen by the memory-space decoder |
| port_word_i | input | NPORTS*W | Incoming word per port, port p at bits p*W +: W |
| port_valid_i | input | NPORTS | Word-valid per port |
| boot_mode_o | output | 1 | Node is in boot mode |
| run_mode_o | output | 1 | Node runs its application schedule |
| boot_port_o | output | PIDX_W | Index of the port owning the boot |
| port_rd_en_o | output | NPORTS | One-hot read enable to the boot port |
| mem_wr_en_o | output | 1 | Write strobe to the memory-space path |
| mem_wr_data_o | output | W | Word forwarded to the memory-space path |
| clr_valid_o | output | 1 | Clear all buffer and processor-interface valid bits |

## Verification
The assertions assume the following about the inputs:
- `boot_exit_i` is a single-cycle pulse.
- `mask_i` is only meaningful while `mask_we_i` is high.
- Neighbour reset lines are synchronous levels that stay stable between edges.

The directed stimulus changes every input one time unit after a rising edge and holds it for whole cycles. It raises and drops reset lines one step at a time, so each lock, takeover and release lands on a known edge. The boot-exit pulse is given only for single cycles, including one cycle where it meets a fresh acceptance.

// File: rtl/bootctl_pkg.sv
package bootctl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BOOT = 2'd1,
    ST_RUN  = 2'd2
  } boot_state_e;

  // index of the least significant set bit, 0 when none is set
  function automatic int first_set_idx(input logic [31:0] vec);
    int idx;
    idx = 0;
    for (int i = 31; i >= 0; i--) begin
      if (vec[i]) idx = i;
    end
    return idx;
  endfunction

  // isolate the least significant set bit
  function automatic logic [31:0] lowest_onehot(input logic [31:0] vec);
    return vec & (~vec + 32'd1);
  endfunction

endpackage

// File: rtl/bootctl_arb.sv
module bootctl_arb
  import bootctl_pkg::*;
#(
  parameter int NPORTS = 4,
  parameter int PIDX_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPORTS-1:0] nbr_rst_i,
  input  logic              mask_we_i,
  input  logic [NPORTS-1:0] mask_i,
  output logic              accept_o,
  output logic [PIDX_W-1:0] win_idx_o,
  output logic [PIDX_W-1:0] owner_o,
  output logic              locked_o
);

  logic [NPORTS-1:0] mask_q;
  logic              locked_q;
  logic [PIDX_W-1:0] owner_q;
  logic [NPORTS-1:0] cand;
  logic [NPORTS-1:0] cand_oh;
  logic              owner_high;
  logic              lock_free;

  assign cand       = nbr_rst_i & ~mask_q;
  assign cand_oh    = NPORTS'(lowest_onehot(32'(cand)));
  assign owner_high = nbr_rst_i[owner_q];
  assign lock_free  = !locked_q || !owner_high;
  assign accept_o   = lock_free && (|cand);
  assign win_idx_o  = PIDX_W'(first_set_idx(32'(cand)));
  assign owner_o    = owner_q;
  assign locked_o   = locked_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (mask_we_i) begin
      mask_q <= mask_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked_q <= 1'b0;
      owner_q  <= '0;
    end else if (accept_o) begin
      locked_q <= 1'b1;
      owner_q  <= win_idx_o;
    end else if (locked_q && !owner_high) begin
      locked_q <= 1'b0;
    end
  end

  AST_OWNER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_q && owner_high) |=> (locked_q && $stable(owner_q))); // R5
  AST_MASKED_NEVER_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o |-> ((cand_oh & mask_q) == '0)); // R9
  AST_WIN_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o |-> ($countones(cand_oh) == 1)); // R4

endmodule

// File: rtl/bootctl_fsm.sv
module bootctl_fsm
  import bootctl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        accept_i,
  input  logic        exit_i,
  output boot_state_e state_o,
  output logic        boot_o,
  output logic        run_o,
  output logic        clr_valid_o
);

  boot_state_e state_q;
  boot_state_e state_d;
  logic        pwr_clr_q;

  always_comb begin
    state_d = state_q;
    if (accept_i) begin
      state_d = ST_BOOT;
    end else if (state_q == ST_BOOT && exit_i) begin
      state_d = ST_RUN;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      pwr_clr_q <= 1'b1;
    end else begin
      state_q   <= state_d;
      pwr_clr_q <= 1'b0;
    end
  end

  assign state_o     = state_q;
  assign boot_o      = (state_q == ST_BOOT);
  assign run_o       = (state_q == ST_RUN);
  assign clr_valid_o = pwr_clr_q;

  AST_ACCEPT_TO_BOOT: assert property (@(posedge clk) disable iff (!rst_n)
    accept_i |=> boot_o); // R2
  AST_EXIT_TO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_o && exit_i && !accept_i) |=> run_o); // R7
  AST_NO_CLR_ON_NBR: assert property (@(posedge clk) disable iff (!rst_n)
    accept_i |=> !clr_valid_o); // R6
  AST_NO_IDLE_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |=> (state_q != ST_IDLE)); // R1

endmodule

// File: rtl/bootctl_fwd.sv
module bootctl_fwd #(
  parameter int NPORTS = 4,
  parameter int W      = 16,
  parameter int PIDX_W = 2
) (
  input  logic                boot_i,
  input  logic [PIDX_W-1:0]   sel_i,
  input  logic [NPORTS*W-1:0] port_word_i,
  input  logic [NPORTS-1:0]   port_valid_i,
  output logic [NPORTS-1:0]   rd_en_o,
  output logic                wr_en_o,
  output logic [W-1:0]        wr_data_o
);

  logic [NPORTS-1:0] hit;
  logic [W-1:0]      masked_word [NPORTS];

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    assign rd_en_o[p]     = boot_i && (sel_i == PIDX_W'(p));
    assign hit[p]         = rd_en_o[p] && port_valid_i[p];
    assign masked_word[p] = rd_en_o[p] ? port_word_i[p*W +: W] : '0;
  end

  always_comb begin
    wr_data_o = '0;
    for (int p = 0; p < NPORTS; p++) begin
      wr_data_o = wr_data_o | masked_word[p];
    end
  end

  assign wr_en_o = |hit;

endmodule

// File: rtl/bootctl_top.sv
module bootctl_top
  import bootctl_pkg::*;
#(
  parameter int NPORTS = 4,
  parameter int W      = 16,
  parameter int PIDX_W = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NPORTS-1:0]   nbr_rst_i,
  input  logic                mask_we_i,
  input  logic [NPORTS-1:0]   mask_i,
  input  logic                boot_exit_i,
  input  logic [NPORTS*W-1:0] port_word_i,
  input  logic [NPORTS-1:0]   port_valid_i,
  output logic                boot_mode_o,
  output logic                run_mode_o,
  output logic [PIDX_W-1:0]   boot_port_o,
  output logic [NPORTS-1:0]   port_rd_en_o,
  output logic                mem_wr_en_o,
  output logic [W-1:0]        mem_wr_data_o,
  output logic                clr_valid_o
);

  logic              accept;
  logic [PIDX_W-1:0] win_idx;
  logic [PIDX_W-1:0] owner;
  logic              locked;
  boot_state_e       state;

  bootctl_arb #(.NPORTS(NPORTS), .PIDX_W(PIDX_W)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .nbr_rst_i (nbr_rst_i),
    .mask_we_i (mask_we_i),
    .mask_i    (mask_i),
    .accept_o  (accept),
    .win_idx_o (win_idx),
    .owner_o   (owner),
    .locked_o  (locked)
  );

  bootctl_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept_i    (accept),
    .exit_i      (boot_exit_i),
    .state_o     (state),
    .boot_o      (boot_mode_o),
    .run_o       (run_mode_o),
    .clr_valid_o (clr_valid_o)
  );

  bootctl_fwd #(.NPORTS(NPORTS), .W(W), .PIDX_W(PIDX_W)) u_fwd (
    .boot_i       (boot_mode_o),
    .sel_i        (owner),
    .port_word_i  (port_word_i),
    .port_valid_i (port_valid_i),
    .rd_en_o      (port_rd_en_o),
    .wr_en_o      (mem_wr_en_o),
    .wr_data_o    (mem_wr_data_o)
  );

  assign boot_port_o = owner;

  AST_WR_NEEDS_BOOT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en_o |-> (boot_mode_o && port_rd_en_o != '0)); // R3
  AST_RD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(port_rd_en_o)); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> (port_rd_en_o == '0 && !mem_wr_en_o)); // R1
  AST_BOOT_IMPLIES_LOCK_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(boot_mode_o) |-> locked); // R2
  AST_PORT_FROM_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (boot_port_o == $past(win_idx))); // R8

endmodule

// File: tb/test_bootctl_top.sv
module test_bootctl_top;

  localparam int NP = 4;
  localparam int W  = 16;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [NP-1:0]   nbr_rst;
  logic            mask_we;
  logic [NP-1:0]   mask;
  logic            bexit;
  logic [NP*W-1:0] pword;
  logic [NP-1:0]   pvalid;
  logic            boot_mode, run_mode, mem_wr_en, clr_valid;
  logic [1:0]      boot_port;
  logic [NP-1:0]   rd_en;
  logic [W-1:0]    mem_wr_data;

  int n_total = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  bootctl_top #(.NPORTS(NP), .W(W)) i_bootctl_top (
    .clk(clk), .rst_n(rst_n), .nbr_rst_i(nbr_rst), .mask_we_i(mask_we),
    .mask_i(mask), .boot_exit_i(bexit), .port_word_i(pword),
    .port_valid_i(pvalid), .boot_mode_o(boot_mode), .run_mode_o(run_mode),
    .boot_port_o(boot_port), .port_rd_en_o(rd_en), .mem_wr_en_o(mem_wr_en),
    .mem_wr_data_o(mem_wr_data), .clr_valid_o(clr_valid)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_total++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic expect_boot(input string req, input int port);
    chk(req, "boot_mode", 32'(boot_mode), 1);
    chk(req, "run_mode", 32'(run_mode), 0);
    chk(req, "boot_port", 32'(boot_port), 32'(port));
    chk(req, "rd_en", 32'(rd_en), 32'(1 << port));
  endtask

  task automatic power_reset();
    rst_n = 1'b0; nbr_rst = '0; mask_we = 1'b0; mask = '0;
    bexit = 1'b0; pword = '0; pvalid = '0;
    tick(); tick();
    chk("R6", "clr in reset", 32'(clr_valid), 1);
    rst_n = 1'b1;
    #1;
    chk("R6", "clr first cycle", 32'(clr_valid), 1);
    chk("R1", "idle boot", 32'(boot_mode), 0);
    chk("R1", "idle run", 32'(run_mode), 0);
    chk("R1", "idle rd_en", 32'(rd_en), 0);
  endtask

  task automatic t_idle_exit();
    pvalid = '1;
    bexit  = 1'b1;
    tick();
    bexit = 1'b0;
    chk("R6", "clr drops", 32'(clr_valid), 0);
    chk("R7", "exit ignored idle boot", 32'(boot_mode), 0);
    chk("R7", "exit ignored idle run", 32'(run_mode), 0);
    chk("R1", "no write idle", 32'(mem_wr_en), 0);
    pvalid = '0;
  endtask

  task automatic t_accept_forward();
    nbr_rst = 4'b0100;
    tick();
    expect_boot("R2", 2);
    chk("R6", "no clr on nbr", 32'(clr_valid), 0);
    pword[2*W +: W] = 16'hA5C3; pword[1*W +: W] = 16'h1111;
    pvalid = 4'b0110;
    #1;
    chk("R3", "wr_en", 32'(mem_wr_en), 1);
    chk("R3", "wr_data", 32'(mem_wr_data), 32'h0000A5C3);
    pvalid = 4'b0010;
    #1;
    chk("R3", "other port ignored", 32'(mem_wr_en), 0);
    pvalid = '0;
  endtask

  task automatic t_lock();
    nbr_rst = 4'b0101;
    tick();
    expect_boot("R5", 2);
    nbr_rst = 4'b0001;
    tick();
    expect_boot("R5", 0);
  endtask

  task automatic t_exit_run();
    bexit = 1'b1;
    tick();
    bexit = 1'b0;
    chk("R7", "run after exit", 32'(run_mode), 1);
    chk("R7", "boot off", 32'(boot_mode), 0);
    pvalid = '1;
    #1;
    chk("R3", "no wr in run", 32'(mem_wr_en), 0);
    chk("R3", "no rd in run", 32'(rd_en), 0);
    pvalid = '0;
    tick();
    chk("R5", "held owner no reentry", 32'(run_mode), 1);
    nbr_rst = '0;
    tick();
    nbr_rst = 4'b1000;
    tick();
    expect_boot("R8", 3);
    chk("R6", "no clr reboot", 32'(clr_valid), 0);
  endtask

  task automatic t_simultaneous();
    bexit = 1'b1;
    tick();
    bexit = 1'b0;
    nbr_rst = '0;
    tick();
    nbr_rst = 4'b1010;
    tick();
    expect_boot("R4", 1);
    nbr_rst = 4'b1000;
    bexit   = 1'b1;
    tick();
    bexit = 1'b0;
    expect_boot("R7", 3);
  endtask

  task automatic t_mask();
    mask_we = 1'b1; mask = 4'b0010;
    tick();
    mask_we = 1'b0; mask = '0;
    bexit = 1'b1;
    tick();
    bexit = 1'b0;
    nbr_rst = '0;
    tick();
    nbr_rst = 4'b0010;
    tick();
    chk("R9", "masked port ignored", 32'(run_mode), 1);
    chk("R9", "masked no boot", 32'(boot_mode), 0);
    nbr_rst = 4'b0110;
    tick();
    expect_boot("R9", 2);
  endtask

  task automatic t_mask_cleared();
    power_reset();
    tick();
    nbr_rst = 4'b0010;
    tick();
    expect_boot("R9", 1);
  endtask

  initial begin
    #100000;
    n_total++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    power_reset();
    t_idle_exit();
    t_accept_forward();
    t_lock();
    t_exit_run();
    t_simultaneous();
    t_mask();
    t_mask_cleared();
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

endmodule